// File: doc/BRIEF.md
# GPIO and Control Register Block

This block is a 16-bit register file that sits on a simple memory-mapped bus. A write strobe, a read strobe, a 6-bit address and 16-bit write data select and update the registers. Read data comes back in the same cycle, with no wait states. Six of the registers are plain storage: mode, clock divider, clock control, interrupt request, interrupt mask and interrupt status. No logic acts on their contents. A power register adds one forcing rule on write. A status register is read-only and holds a fixed value.

The block also contains a 16-line GPIO unit. It has a direction register and a level register. The level register can be reached at two bus offsets. Bus writes to the level register are masked by the direction register. Per-line input events set or clear level bits. The driven outputs show the level gated by the direction. They are refreshed only when the direction or level register is written. On that refresh, a one-cycle change pulse fires on each line whose driven value actually changed.

Top module: `pio_regfile`

## Requirements
- R1: After reset every register reads 0x0000 except status, which reads 0x0002. The outputs `gpioOut` and `gpioChg` are zero, and the stored previous output value is zero.
- R2: The plain registers keep the last written value and return it on reads. Their offsets are mode 0x00, clock divider 0x04, clock control 0x10, interrupt request 0x14, interrupt mask 0x18 and interrupt status 0x1C.
- R3: A write at offset 0x0C stores the data in the power register. If bit 7 of the data is 1, bits 15 and 6 of the stored value are also forced to 1.
- R4: Offset 0x08 always reads 0x0002. A write there changes nothing.
- R5: A write at offset 0x24 or 0x28 stores the write data ANDed with the current direction register (offset 0x20) into the level register. A read at either offset returns the level register.
- R6: `gpioOut` equals level AND direction as they stand after a write to offset 0x20, 0x24 or 0x28. It updates on the clock edge that ends that write and holds until the next such write.
- R7: On the edge where `gpioOut` is refreshed, `gpioChg` is high for exactly one cycle on the lines whose new value differs from the previous `gpioOut`, and low on every other line. At all other times it is zero.
- R8: For every line where `gpioEvtValid` is high, the level bit takes the value of `gpioEvtLevel` at the next edge. Such an update alone does not change `gpioOut` or `gpioChg`.
- R9: When a bus level write and an input event land in the same cycle, the bus write decides every level bit and the event is dropped.
- R10: A read at an offset with no register returns zero, and so does any cycle without the read strobe. A write to such an offset changes no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busAddr | input | 6 | Register byte offset |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data, combinational from address |
| gpioEvtValid | input | 16 | Per-line input event enable |
| gpioEvtLevel | input | 16 | Per-line input event value |
| gpioOut | output | 16 | Driven lines: level gated by direction |
| gpioChg | output | 16 | One-cycle per-line change pulse |

## Verification
The GPIO path is driven with random direction masks, random level data and random input events. Each pattern targets a different behaviour. Level writes under sparse direction masks show whether the direction mask is applied. Direction writes over a stable level show whether the refresh also happens on a direction write and not only on a level write. Event-only cycles show whether the outputs wrongly follow the inputs. Rewriting the same value shows that `gpioChg` stays quiet when no line changes. Directed cases cover power writes with bit 7 set and clear, status writes, a same-cycle collision between an event and a level write, and writes to unmapped offsets.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 6;
  localparam int NUM_PLAIN = 6;
  localparam int PIDX_W    = $clog2(NUM_PLAIN);

  // Byte offsets decoded from the low address bits
  localparam logic [ADDR_W-1:0] OFS_MODE    = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CLKDIV  = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_STATUS  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_POWER   = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_CLKCTL  = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IRQREQ  = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IRQMASK = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_IRQSTAT = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 6'h20;
  localparam logic [ADDR_W-1:0] OFS_LVLA    = 6'h24;
  localparam logic [ADDR_W-1:0] OFS_LVLB    = 6'h28;

  localparam logic [REG_W-1:0] STATUS_VAL  = 16'h0002;
  localparam logic [REG_W-1:0] POWER_FORCE = 16'h8040;
  localparam int               POWER_TRIG  = 7;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PLAIN,
    SEL_STATUS,
    SEL_POWER,
    SEL_DIR,
    SEL_LEVEL
  } rdSel_e;

  typedef struct packed {
    logic [NUM_PLAIN-1:0] wrPlain;
    logic                 wrPower;
    logic                 wrDir;
    logic                 wrLevel;
    rdSel_e               rdSel;
    logic [PIDX_W-1:0]    plainIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          busWr,
  input  logic          busRd,
  input  logic [AW-1:0] busAddr,
  output ctlStrobe_t    st
);
  logic [NUM_PLAIN-1:0] plainHit;
  logic [PIDX_W-1:0]    plainIdx;
  logic                 anyPlain;

  // Plain storage slots: 0 mode, 1 clkdiv, 2 clkctl, 3 irqreq, 4 irqmask, 5 irqstat
  always_comb begin
    plainHit = '0;
    plainIdx = '0;
    unique case (busAddr)
      OFS_MODE:    begin plainHit[0] = 1'b1; plainIdx = 3'd0; end
      OFS_CLKDIV:  begin plainHit[1] = 1'b1; plainIdx = 3'd1; end
      OFS_CLKCTL:  begin plainHit[2] = 1'b1; plainIdx = 3'd2; end
      OFS_IRQREQ:  begin plainHit[3] = 1'b1; plainIdx = 3'd3; end
      OFS_IRQMASK: begin plainHit[4] = 1'b1; plainIdx = 3'd4; end
      OFS_IRQSTAT: begin plainHit[5] = 1'b1; plainIdx = 3'd5; end
      default:     ;
    endcase
  end

  assign anyPlain = |plainHit;

  always_comb begin
    st          = '0;
    st.wrPlain  = busWr ? plainHit : '0;
    st.wrPower  = busWr && (busAddr == OFS_POWER);
    st.wrDir    = busWr && (busAddr == OFS_DIR);
    st.wrLevel  = busWr && ((busAddr == OFS_LVLA) || (busAddr == OFS_LVLB));
    st.plainIdx = plainIdx;
    st.rdSel    = SEL_NONE;
    if (busRd) begin
      if (anyPlain)                                            st.rdSel = SEL_PLAIN;
      else if (busAddr == OFS_STATUS)                          st.rdSel = SEL_STATUS;
      else if (busAddr == OFS_POWER)                           st.rdSel = SEL_POWER;
      else if (busAddr == OFS_DIR)                             st.rdSel = SEL_DIR;
      else if ((busAddr == OFS_LVLA) || (busAddr == OFS_LVLB)) st.rdSel = SEL_LEVEL;
      else                                                     st.rdSel = SEL_NONE;
    end
  end
endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    st,
  input  logic [DW-1:0] busWdata,
  input  logic [DW-1:0] gpioEvtValid,
  input  logic [DW-1:0] gpioEvtLevel,
  output logic [DW-1:0] busRdata,
  output logic [DW-1:0] gpioOut,
  output logic [DW-1:0] gpioChg
);
  logic [DW-1:0] plainQ [NUM_PLAIN];
  logic [DW-1:0] powerQ, dirQ, levelQ, outQ, chgQ;
  logic [DW-1:0] dirNext, levelNext, gatedNext, powerData;
  logic          refresh;

  // Plain storage registers
  for (genvar g = 0; g < NUM_PLAIN; g++) begin : gPlain
    always_ff @(posedge clk) begin
      if (!rstN)              plainQ[g] <= '0;
      else if (st.wrPlain[g]) plainQ[g] <= busWdata;
    end
  end

  // Power register with forcing rule
  assign powerData = busWdata[POWER_TRIG] ? (busWdata | POWER_FORCE) : busWdata;

  always_ff @(posedge clk) begin
    if (!rstN)           powerQ <= '0;
    else if (st.wrPower) powerQ <= powerData;
  end

  // GPIO direction and level
  assign dirNext = st.wrDir ? busWdata : dirQ;

  for (genvar i = 0; i < DW; i++) begin : gLine
    always_comb begin
      if (st.wrLevel)           levelNext[i] = busWdata[i] & dirQ[i];
      else if (gpioEvtValid[i]) levelNext[i] = gpioEvtLevel[i];
      else                      levelNext[i] = levelQ[i];
    end
  end

  assign gatedNext = levelNext & dirNext;
  assign refresh   = st.wrDir | st.wrLevel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dirQ   <= '0;
      levelQ <= '0;
      outQ   <= '0;
      chgQ   <= '0;
    end else begin
      dirQ   <= dirNext;
      levelQ <= levelNext;
      if (refresh) begin
        outQ <= gatedNext;
        chgQ <= gatedNext ^ outQ;
      end else begin
        chgQ <= '0;
      end
    end
  end

  // Read mux
  always_comb begin
    unique case (st.rdSel)
      SEL_PLAIN:  busRdata = plainQ[st.plainIdx];
      SEL_STATUS: busRdata = STATUS_VAL;
      SEL_POWER:  busRdata = powerQ;
      SEL_DIR:    busRdata = dirQ;
      SEL_LEVEL:  busRdata = levelQ;
      default:    busRdata = '0;
    endcase
  end

  assign gpioOut = outQ;
  assign gpioChg = chgQ;

  assert_out_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outQ & ~dirQ) == '0);

  assert_chg_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    refresh |=> (chgQ == (outQ ^ $past(outQ))));

  assert_chg_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !refresh |=> (chgQ == '0) && $stable(outQ));

  assert_level_masked_R5: assert property (@(posedge clk) disable iff (!rstN)
    st.wrLevel |=> (levelQ & ~$past(dirQ)) == '0);

  assert_power_force_R3: assert property (@(posedge clk) disable iff (!rstN)
    (st.wrPower && busWdata[POWER_TRIG]) |=> (powerQ & POWER_FORCE) == POWER_FORCE);

  assert_status_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (st.rdSel == SEL_STATUS) |-> busRdata == STATUS_VAL);
endmodule

// File: rtl/pio_regfile.sv
module pio_regfile
  import pio_pkg::*;
#(
  parameter int DW = REG_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic [DW-1:0] gpioEvtValid,
  input  logic [DW-1:0] gpioEvtLevel,
  output logic [DW-1:0] gpioOut,
  output logic [DW-1:0] gpioChg
);
  ctlStrobe_t st;
  logic       addrMapped;

  pio_ctrl #(.AW(AW)) uCtrl (
    .busWr   (busWr),
    .busRd   (busRd),
    .busAddr (busAddr),
    .st      (st)
  );

  pio_datapath #(.DW(DW)) uData (
    .clk          (clk),
    .rstN         (rstN),
    .st           (st),
    .busWdata     (busWdata),
    .gpioEvtValid (gpioEvtValid),
    .gpioEvtLevel (gpioEvtLevel),
    .busRdata     (busRdata),
    .gpioOut      (gpioOut),
    .gpioChg      (gpioChg)
  );

  assign addrMapped = busAddr inside {OFS_MODE, OFS_CLKDIV, OFS_STATUS, OFS_POWER,
                                      OFS_CLKCTL, OFS_IRQREQ, OFS_IRQMASK, OFS_IRQSTAT,
                                      OFS_DIR, OFS_LVLA, OFS_LVLB};

  assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busRd || !addrMapped) |-> busRdata == '0);

  assert_unmapped_nochg_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && !addrMapped) |=> gpioChg == '0);
endmodule

// File: tb/sim_pio_regfile.sv
module sim_pio_regfile;
  import pio_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0, busRd = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [15:0] busWdata = '0, busRdata;
  logic [15:0] gpioEvtValid = '0, gpioEvtLevel = '0;
  logic [15:0] gpioOut, gpioChg;

  int vectors = 0;
  int miscompares = 0;

  // Bench model
  logic [15:0] mPlain [6];
  logic [15:0] mPower, mDir, mLevel, mOut, mChg;

  always #5 clk = ~clk;

  pio_regfile u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .gpioEvtValid(gpioEvtValid),
    .gpioEvtLevel(gpioEvtLevel), .gpioOut(gpioOut), .gpioChg(gpioChg)
  );

  function automatic int plainSlot(input logic [5:0] a);
    case (a)
      6'h00: return 0;
      6'h04: return 1;
      6'h10: return 2;
      6'h14: return 3;
      6'h18: return 4;
      6'h1C: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] expRead(input logic [5:0] a);
    if (plainSlot(a) >= 0) return mPlain[plainSlot(a)];
    case (a)
      6'h08:        return 16'h0002;
      6'h0C:        return mPower;
      6'h20:        return mDir;
      6'h24, 6'h28: return mLevel;
      default:      return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int k = 0; k < 6; k++) mPlain[k] = '0;
    mPower = '0; mDir = '0; mLevel = '0; mOut = '0; mChg = '0;
  endtask

  // One bus cycle with optional write and input event, then output checks
  task automatic cycle(input logic wr, input logic [5:0] a, input logic [15:0] d,
                       input logic [15:0] ev, input logic [15:0] el, input string tag);
    logic [15:0] nDir, nLvl;
    logic        isLvl, refresh;
    @(negedge clk);
    busWr = wr; busAddr = a; busWdata = d; gpioEvtValid = ev; gpioEvtLevel = el;
    @(posedge clk); #1;
    busWr = 1'b0; gpioEvtValid = '0;
    isLvl = wr && (a == 6'h24 || a == 6'h28);
    nDir  = (wr && a == 6'h20) ? d : mDir;
    nLvl  = isLvl ? (d & mDir) : ((mLevel & ~ev) | (el & ev));
    if (wr && plainSlot(a) >= 0) mPlain[plainSlot(a)] = d;
    if (wr && a == 6'h0C) mPower = d[7] ? (d | 16'h8040) : d;
    refresh = isLvl || (wr && a == 6'h20);
    if (refresh) begin
      mChg = (nLvl & nDir) ^ mOut;
      mOut = nLvl & nDir;
    end else begin
      mChg = '0;
    end
    mDir = nDir; mLevel = nLvl;
    chk({tag, " R6 gpioOut"}, gpioOut, mOut);
    chk({tag, " R7 gpioChg"}, gpioChg, mChg);
  endtask

  task automatic rdChk(input logic [5:0] a, input string tag);
    @(negedge clk);
    busRd = 1'b1; busAddr = a; #1;
    chk(tag, busRdata, expRead(a));
    busRd = 1'b0;
  endtask

  task automatic rdAll(input string tag);
    for (int k = 0; k < 12; k++) rdChk(6'(k * 4), tag);
  endtask

  logic [5:0] addrPool [13] = '{6'h00, 6'h04, 6'h08, 6'h0C, 6'h10, 6'h14, 6'h18,
                                6'h1C, 6'h20, 6'h24, 6'h28, 6'h2C, 6'h3E};

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 gpioOut", gpioOut, 16'h0);
    chk("R1 gpioChg", gpioChg, 16'h0);
    @(negedge clk); rstN = 1'b1;
    rdAll("R1 reset read");

    // R2: plain registers
    cycle(1'b1, 6'h00, 16'hA5C3, '0, '0, "R2");
    cycle(1'b1, 6'h1C, 16'h1234, '0, '0, "R2");
    cycle(1'b1, 6'h14, 16'hFFFF, '0, '0, "R2");
    rdAll("R2 plain readback");

    // R3: power forcing
    cycle(1'b1, 6'h0C, 16'h0080, '0, '0, "R3");
    rdChk(6'h0C, "R3 power bit7 set");
    cycle(1'b1, 6'h0C, 16'h0101, '0, '0, "R3");
    rdChk(6'h0C, "R3 power bit7 clear");

    // R4: status write ignored
    cycle(1'b1, 6'h08, 16'hFFFF, '0, '0, "R4");
    rdChk(6'h08, "R4 status");

    // R5/R6/R7: directed GPIO
    cycle(1'b1, 6'h24, 16'hFFFF, '0, '0, "R5 level with dir zero");
    rdChk(6'h24, "R5 level masked");
    cycle(1'b1, 6'h20, 16'h00F0, '0, '0, "R6 dir write");
    cycle(1'b1, 6'h28, 16'hFFFF, '0, '0, "R5 alt offset");
    rdChk(6'h24, "R5 read 0x24");
    rdChk(6'h28, "R5 read 0x28");
    cycle(1'b1, 6'h28, 16'hFFFF, '0, '0, "R7 same value no change");
    cycle(1'b0, 6'h00, 16'h0, '0, '0, "R7 pulse cleared");

    // R8: event updates level but not output
    cycle(1'b0, 6'h00, 16'h0, 16'h0F30, 16'h0A10, "R8 event");
    rdChk(6'h24, "R8 level after event");
    cycle(1'b1, 6'h20, 16'h0FF0, '0, '0, "R8 refresh after event");

    // R9: collision
    cycle(1'b1, 6'h24, 16'h00F0, 16'hFFFF, 16'h0000, "R9 collision");
    rdChk(6'h24, "R9 level after collision");

    // R10: unmapped offsets
    cycle(1'b1, 6'h2C, 16'hFFFF, '0, '0, "R10 unmapped write");
    cycle(1'b1, 6'h3C, 16'hFFFF, '0, '0, "R10 unmapped write");
    rdChk(6'h2C, "R10 unmapped read");
    rdChk(6'h30, "R10 unmapped read");
    rdAll("R10 nothing changed");

    // Random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 600; n++) begin
      int op;
      logic [5:0] a;
      op = int'($urandom_range(0, 9));
      a  = addrPool[$urandom_range(0, 12)];
      if (op < 4)      cycle(1'b1, a, 16'($urandom), '0, '0, "R5 random write");
      else if (op < 6) cycle(1'b1, (op == 4) ? 6'h20 : 6'h24, 16'($urandom), '0, '0, "R6 random gpio");
      else if (op < 8) cycle(1'b0, 6'h00, 16'h0, 16'($urandom), 16'($urandom), "R8 random event");
      else if (op < 9) cycle(1'b1, 6'h28, 16'($urandom), 16'($urandom), 16'($urandom), "R9 random collision");
      else             rdChk(a, "R2 random read");
    end
    rdAll("R2 final readback");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule